// File: doc/BRIEF.md
# Byte-Lane Write Enable Control

This block sits between the write-control pins of a synchronous memory and its lane write drivers. Each rising clock edge it samples a 36-bit data word, arranged as four 9-bit lanes, together with three kinds of active-low write control: a global write, a byte-write qualifier and one select per lane. From these it decides which lanes the cycle writes. It then registers that decision as four lane strobes, on the same edge as the write address and the lane data.

A low global write forces every lane to be written. If the global write is high, a low byte-write qualifier lets the lane selects pick any subset of lanes. If both are high, the cycle writes nothing and counts as a read. Each lane has its own data register. That register loads only when its lane is written, so the drivers of lanes left alone see their previous contents unchanged.

Top module: `lane_write_ctrl`

## Requirements
- R1: While the active-low reset is asserted, all lane strobes, the write-active flag, the registered address and the registered data are zero.
- R2: If the global write input is low at a clock edge, all four lane strobes are high after that edge, whatever the byte-write qualifier and lane selects are.
- R3: If the global write is high and the byte-write qualifier is low at an edge, strobe n (bit n of the strobe vector) is high after that edge exactly when lane select n (bit n of the select vector) is low.
- R4: If the global write and the byte-write qualifier are both high at an edge, no strobe is high after that edge.
- R5: A lane written at an edge holds, after that edge, the input bits of that lane. Lane n covers data bits 9n+8 down to 9n, and bit 9n+8 is the lane's parity bit.
- R6: A lane not written at an edge keeps its registered data unchanged.
- R7: The registered write address after every edge equals the address input sampled at that edge, so the strobes and the address always refer to the same cycle.
- R8: The write-active output is high exactly when at least one lane strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 17 | Address of the current cycle |
| glob_wr_n | input | 1 | Global write, active low; writes all lanes |
| byte_en_n | input | 1 | Byte-write qualifier, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low, bit n = lane n |
| data_in | input | 36 | Write data, four 9-bit lanes |
| lane_wr | output | 4 | Registered lane write strobes, active high |
| wr_any | output | 1 | High when any lane strobe is high |
| wr_addr | output | 17 | Address registered with the strobes |
| wr_data | output | 36 | Per-lane registered write data |

## Verification
On every cycle after reset, the assertions check the priority decode: global write over byte write over read. They also check that the address is aligned with the strobes and that each lane's data holds whenever that lane is not written. Only the bench's scenarios show three further things. The first is that a written lane captures exactly its own nine bits, parity bit included, from varied data patterns. The second is that the write-active flag matches the strobes. The third is the reset values. The bench sweeps all 64 combinations of the write controls over several rounds of data and compares against a lane-by-lane model.

// File: rtl/lane_write_ctrl.sv
module lane_write_ctrl #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 17,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              glob_wr_n,
  input  logic              byte_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [LANES-1:0]  lane_wr,
  output logic              wr_any,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic [LANES-1:0] lane_go;

  assign lane_go = !glob_wr_n ? {LANES{1'b1}} :
                   !byte_en_n ? ~lane_sel_n   : {LANES{1'b0}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_wr <= '0;
      wr_addr <= '0;
    end else begin
      lane_wr <= lane_go;
      wr_addr <= addr_in;
    end
  end

  assign wr_any = |lane_wr;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wr_data[i*LANE_W +: LANE_W] <= '0;
      else if (lane_go[i])
        wr_data[i*LANE_W +: LANE_W] <= data_in[i*LANE_W +: LANE_W];
    end

    p_lane_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !lane_wr[i] |-> $stable(wr_data[i*LANE_W +: LANE_W]))
      else $error("R6 lane %0d data changed without a write", i);
  end

  p_global_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(glob_wr_n) |-> &lane_wr)
    else $error("R2 global write did not strobe all lanes");

  p_byte_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(glob_wr_n) && !$past(byte_en_n) |-> lane_wr == ~$past(lane_sel_n))
    else $error("R3 lane strobes do not follow selects");

  p_read_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(glob_wr_n) && $past(byte_en_n) |-> lane_wr == '0)
    else $error("R4 strobe during read cycle");

  p_addr_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> wr_addr == $past(addr_in))
    else $error("R7 address not aligned with strobes");

endmodule

// File: tb/lane_write_ctrl_tb.sv
module lane_write_ctrl_tb;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int ADDR_W = 17;
  localparam int DATA_W = LANES * LANE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              glob_wr_n = 1'b1;
  logic              byte_en_n = 1'b1;
  logic [LANES-1:0]  lane_sel_n = '1;
  logic [DATA_W-1:0] data_in = '0;
  logic [LANES-1:0]  lane_wr;
  logic              wr_any;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_write_ctrl #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .glob_wr_n(glob_wr_n),
    .byte_en_n(byte_en_n), .lane_sel_n(lane_sel_n), .data_in(data_in),
    .lane_wr(lane_wr), .wr_any(wr_any), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [DATA_W-1:0] model;
  logic [LANES-1:0]  exp_wr;

  initial begin
    model = '0;
    repeat (3) @(negedge clk);
    check("R1 strobes", 64'(lane_wr), 64'h0);
    check("R1 any", 64'(wr_any), 64'h0);
    check("R1 addr", 64'(wr_addr), 64'h0);
    check("R1 data", 64'(wr_data), 64'h0);
    rst_n = 1'b1;
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int c = 0; c < 64; c++) begin
        glob_wr_n  = c[5];
        byte_en_n  = c[4];
        lane_sel_n = c[3:0];
        addr_in    = ADDR_W'((c * 977 + rnd * 31337) ^ 17'h15a5a);
        data_in    = DATA_W'((64'(c) + 1) * 64'h9_1357_ace1 + 64'(rnd) * 64'h3_c0ff_ee55);
        if (!glob_wr_n)      exp_wr = '1;
        else if (!byte_en_n) exp_wr = ~lane_sel_n;
        else                 exp_wr = '0;
        for (int l = 0; l < LANES; l++)
          if (exp_wr[l]) model[l*LANE_W +: LANE_W] = data_in[l*LANE_W +: LANE_W];
        @(posedge clk);
        @(negedge clk);
        if (!glob_wr_n)      check("R2 global write strobes", 64'(lane_wr), 64'(exp_wr));
        else if (!byte_en_n) check("R3 byte select strobes", 64'(lane_wr), 64'(exp_wr));
        else                 check("R4 read cycle strobes", 64'(lane_wr), 64'(exp_wr));
        if (exp_wr != '0) check("R5 written lane data", 64'(wr_data), 64'(model));
        if (exp_wr != '1) check("R6 unwritten lanes held", 64'(wr_data), 64'(model));
        check("R7 address alignment", 64'(wr_addr), 64'(addr_in));
        check("R8 write active", 64'(wr_any), 64'(exp_wr != '0));
      end
    end
    rst_n = 1'b0;
    #1;
    check("R1 strobes after reset", 64'(lane_wr), 64'h0);
    check("R1 data after reset", 64'(wr_data), 64'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule